// File: doc/BRIEF.md
# Three-Mode 4:2:2 Byte-Bus Video Capture

This block sits at the pixel input of a video path. An upstream decoder delivers interleaved YCrCb 4:2:2 bytes on an 8-bit bus, and the block splits them into a stream of luma samples. Each luma sample carries its co-sited chroma byte, together with a flag that tells Cb from Cr. The block also produces line and field timing.

The bus can run in three ways, chosen by a 3-bit mode input:
- single-rate standard definition at the base clock;
- double-rate enhanced or high definition, with luma and chroma on opposite clock edges;
- single-rate enhanced definition on a clock twice as fast.

Line timing comes from embedded codes: a preamble of all-ones, zero, zero, followed by a status byte. Two modes also accept external horizontal and vertical sync.

The output stream uses a valid strobe with no ready. A video source cannot be stalled, so the consumer must take every sample in the cycle in which `pix_valid` is high. Nothing is buffered, and a sample that is not taken is lost.

Top module: `yc422_capture`

## Requirements
- R1: After reset, `pix_valid`, `eav_pulse`, `sav_pulse` and `field_flag` are 0, and `hblank_flag` and `vblank_flag` are 1.
- R2: In the single-rate modes, four bus bytes 0xFF, 0x00, 0x00 and S mark a timing code, with S as the status byte. In the double-rate mode the code arrives as two consecutive cycles: the first cycle carries 0xFF then 0x00, and the second carries 0x00 then S. The byte on the rising edge comes first. Status bit 4 (H) set gives a one-cycle `eav_pulse`, and H clear gives a one-cycle `sav_pulse`. The pulse appears two clock cycles after the rising edge that sampled the first byte of the cycle carrying S.
- R3: In the same cycle as the pulse, `field_flag` takes status bit 6 and the embedded vertical state takes status bit 5. The embedded horizontal state takes bit 4. All three hold until the next code.
- R4: The single-rate modes share one byte order after an SAV: Cb, Y, Cr, Y, repeating. The block emits one sample on each luma byte, paired with the chroma byte just before it. `pix_c_is_cr` is 0 for the first sample after an SAV and then alternates. The sample appears two cycles after the luma byte is sampled.
- R5: In the double-rate mode, `luma_edge` = 00 takes luma on the rising edge and chroma on the falling edge. Any other value takes luma on the falling edge and chroma on the rising edge. The block emits one sample per clock cycle, and `pix_c_is_cr` alternates starting at 0 after an SAV.
- R6: `pix_valid` is high only between an SAV and the next EAV. While that window is open, a 0xFF byte (the rising-edge byte in double-rate mode) closes it at once, so no byte of a timing code is emitted.
- R7: In modes 000 and 010, `hsync_in` high (active high) forces `hblank_flag` high and pauses sample capture. `vsync_in` high forces `vblank_flag` high. Both inputs pass through the same two-cycle latency as the data.
- R8: In mode 111, `hsync_in` and `vsync_in` have no effect on any output.
- R9: Any mode code other than 000, 010 and 111 produces no sample and no timing pulse.
- R10: Bus bit 0 is the LSB of every sample: `pix_y` and `pix_c` reproduce the captured bytes bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock; data sampled on the rising edge, and also on the falling edge in double-rate mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Bus format: 000 SD single-rate, 010 double-rate, 111 ED single-rate |
| luma_edge | input | 2 | Double-rate luma edge: 00 rising, otherwise falling |
| bus_d | input | 8 | Pixel and timing-code bytes, bit 0 is the LSB |
| hsync_in | input | 1 | External horizontal blanking, active high |
| vsync_in | input | 1 | External vertical blanking, active high |
| pix_valid | output | 1 | A sample is present this cycle |
| pix_y | output | 8 | Luma sample |
| pix_c | output | 8 | Chroma sample co-sited with the luma |
| pix_c_is_cr | output | 1 | 1 when `pix_c` is Cr, 0 when Cb |
| eav_pulse | output | 1 | One-cycle pulse on a decoded end-of-active code |
| sav_pulse | output | 1 | One-cycle pulse on a decoded start-of-active code |
| field_flag | output | 1 | Field bit from the latest code |
| vblank_flag | output | 1 | Vertical blanking, from the embedded code or the external pin |
| hblank_flag | output | 1 | Horizontal blanking, from the embedded code or the external pin |

## Verification
The assertions assume that pixel bytes never take the reserved values 0x00 and 0xFF. They also assume that in double-rate mode the 0xFF of every preamble falls on the rising edge. Under those two conditions, pulses cannot repeat or coincide, and single-rate samples cannot come back to back. The stimulus draws all pixel values from 0x01 to 0xFE. It starts every double-rate code on a rising edge, and it changes the mode and edge select only just after a rising edge, between lines.

// File: rtl/yc422_cap_pkg.sv
`timescale 1ns/1ps
package yc422_cap_pkg;
  localparam logic [2:0] MODE_SD   = 3'b000;
  localparam logic [2:0] MODE_DDR  = 3'b010;
  localparam logic [2:0] MODE_ED54 = 3'b111;

  localparam int STAT_F_BIT = 6;
  localparam int STAT_V_BIT = 5;
  localparam int STAT_H_BIT = 4;

  typedef struct packed {
    logic fld;
    logic vbl;
    logic hbl;
  } code_flags_t;
endpackage

// File: rtl/yc422_cap_front.sv
`timescale 1ns/1ps
module yc422_cap_front #(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_d,
  input  logic          hs_in,
  input  logic          vs_in,
  output logic [DW-1:0] lead_q,
  output logic [DW-1:0] trail_q,
  output logic          hs_q,
  output logic          vs_q
);
  logic [DW-1:0] rise_cap, fall_cap;
  logic [SYNC_STAGES-1:0] hs_pipe, vs_pipe;

  // rising-edge byte (first of the cycle)
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rise_cap <= '0;
    else        rise_cap <= bus_d;

  // falling-edge byte (second of the cycle)
  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) fall_cap <= '0;
    else        fall_cap <= bus_d;

  // realign both bytes into the rising-edge domain as one pair
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lead_q  <= '0;
      trail_q <= '0;
    end else begin
      lead_q  <= rise_cap;
      trail_q <= fall_cap;
    end

  // sync pins follow the same latency as the byte pair
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          hs_pipe[i] <= 1'b0;
          vs_pipe[i] <= 1'b0;
        end else if (i == 0) begin
          hs_pipe[i] <= hs_in;
          vs_pipe[i] <= vs_in;
        end else begin
          hs_pipe[i] <= hs_pipe[(i > 0) ? i-1 : 0];
          vs_pipe[i] <= vs_pipe[(i > 0) ? i-1 : 0];
        end
    end
  endgenerate

  assign hs_q = hs_pipe[SYNC_STAGES-1];
  assign vs_q = vs_pipe[SYNC_STAGES-1];
endmodule

// File: rtl/yc422_cap_timing.sv
`timescale 1ns/1ps
module yc422_cap_timing
  import yc422_cap_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sr_mode,
  input  logic          ddr_mode,
  input  logic [DW-1:0] lead,
  input  logic [DW-1:0] trail,
  output logic          hit,
  output code_flags_t   flags
);
  localparam logic [DW-1:0] ONES = {DW{1'b1}};
  localparam logic [DW-1:0] ZERO = {DW{1'b0}};

  logic [DW-1:0] prev_lead, prev_trail, old2, old3;
  logic          hit_sr, hit_ddr;
  logic [DW-1:0] stat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_lead  <= '0;
      prev_trail <= '0;
      old2       <= '0;
      old3       <= '0;
    end else begin
      prev_lead  <= lead;
      prev_trail <= trail;
      old2       <= prev_lead;
      old3       <= old2;
    end

  always_comb begin
    hit_sr  = (old3 == ONES) && (old2 == ZERO) && (prev_lead == ZERO);
    hit_ddr = (prev_lead == ONES) && (prev_trail == ZERO) && (lead == ZERO);
    hit     = sr_mode ? hit_sr : (ddr_mode && hit_ddr);
    stat    = sr_mode ? lead : trail;
    flags.fld = stat[STAT_F_BIT];
    flags.vbl = stat[STAT_V_BIT];
    flags.hbl = stat[STAT_H_BIT];
  end
endmodule

// File: rtl/yc422_cap_track.sv
`timescale 1ns/1ps
module yc422_cap_track
  import yc422_cap_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ok,
  input  logic          ddr_mode,
  input  logic          ext_ok,
  input  logic          luma_lead,
  input  logic [DW-1:0] lead,
  input  logic [DW-1:0] trail,
  input  logic          hs,
  input  logic          vs,
  input  logic          hit,
  input  code_flags_t   flags,
  output logic          pix_valid,
  output logic [DW-1:0] pix_y,
  output logic [DW-1:0] pix_c,
  output logic          pix_c_is_cr,
  output logic          eav_pulse,
  output logic          sav_pulse,
  output logic          field_flag,
  output logic          vblank_flag,
  output logic          hblank_flag
);
  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  logic          active, luma_due, cr_next;
  logic [DW-1:0] c_hold;
  logic          h_state, v_state;
  logic          h_ext, v_ext, code_ok, h_next, v_next;

  always_comb begin
    h_ext   = ext_ok && hs;
    v_ext   = ext_ok && vs;
    code_ok = mode_ok && hit;
    h_next  = code_ok ? flags.hbl : h_state;
    v_next  = code_ok ? flags.vbl : v_state;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active      <= 1'b0;
      luma_due    <= 1'b0;
      cr_next     <= 1'b0;
      c_hold      <= '0;
      h_state     <= 1'b1;
      v_state     <= 1'b1;
      field_flag  <= 1'b0;
      pix_valid   <= 1'b0;
      pix_y       <= '0;
      pix_c       <= '0;
      pix_c_is_cr <= 1'b0;
      eav_pulse   <= 1'b0;
      sav_pulse   <= 1'b0;
      hblank_flag <= 1'b1;
      vblank_flag <= 1'b1;
    end else begin
      pix_valid   <= 1'b0;
      eav_pulse   <= 1'b0;
      sav_pulse   <= 1'b0;
      h_state     <= h_next;
      v_state     <= v_next;
      hblank_flag <= h_next | h_ext;
      vblank_flag <= v_next | v_ext;
      if (!mode_ok) begin
        active <= 1'b0;
      end else if (hit) begin
        field_flag <= flags.fld;
        eav_pulse  <= flags.hbl;
        sav_pulse  <= ~flags.hbl;
        active     <= ~flags.hbl;
        luma_due   <= 1'b0;
        cr_next    <= 1'b0;
      end else if (active && lead == ONES) begin
        active <= 1'b0;
      end else if (active && !h_ext) begin
        if (ddr_mode) begin
          pix_y       <= luma_lead ? lead : trail;
          pix_c       <= luma_lead ? trail : lead;
          pix_c_is_cr <= cr_next;
          cr_next     <= ~cr_next;
          pix_valid   <= 1'b1;
        end else if (!luma_due) begin
          c_hold   <= lead;
          luma_due <= 1'b1;
        end else begin
          pix_y       <= lead;
          pix_c       <= c_hold;
          pix_c_is_cr <= cr_next;
          cr_next     <= ~cr_next;
          luma_due    <= 1'b0;
          pix_valid   <= 1'b1;
        end
      end
    end
endmodule

// File: rtl/yc422_capture.sv
`timescale 1ns/1ps
module yc422_capture
  import yc422_cap_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_sel,
  input  logic [1:0]    luma_edge,
  input  logic [DW-1:0] bus_d,
  input  logic          hsync_in,
  input  logic          vsync_in,
  output logic          pix_valid,
  output logic [DW-1:0] pix_y,
  output logic [DW-1:0] pix_c,
  output logic          pix_c_is_cr,
  output logic          eav_pulse,
  output logic          sav_pulse,
  output logic          field_flag,
  output logic          vblank_flag,
  output logic          hblank_flag
);
  logic [DW-1:0] lead_b, trail_b;
  logic          hs_al, vs_al;
  logic          sr_mode, ddr_mode, mode_ok, ext_ok, luma_lead;
  logic          code_hit;
  code_flags_t   code_fl;

  always_comb begin
    sr_mode   = (mode_sel == MODE_SD) || (mode_sel == MODE_ED54);
    ddr_mode  = (mode_sel == MODE_DDR);
    mode_ok   = sr_mode || ddr_mode;
    ext_ok    = (mode_sel == MODE_SD) || (mode_sel == MODE_DDR);
    luma_lead = (luma_edge == 2'b00);
  end

  yc422_cap_front #(.DW(DW), .SYNC_STAGES(2)) u_front (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .hs_in(hsync_in), .vs_in(vsync_in),
    .lead_q(lead_b), .trail_q(trail_b), .hs_q(hs_al), .vs_q(vs_al)
  );

  yc422_cap_timing #(.DW(DW)) u_timing (
    .clk(clk), .rst_n(rst_n), .sr_mode(sr_mode), .ddr_mode(ddr_mode),
    .lead(lead_b), .trail(trail_b), .hit(code_hit), .flags(code_fl)
  );

  yc422_cap_track #(.DW(DW)) u_track (
    .clk(clk), .rst_n(rst_n), .mode_ok(mode_ok), .ddr_mode(ddr_mode),
    .ext_ok(ext_ok), .luma_lead(luma_lead), .lead(lead_b), .trail(trail_b),
    .hs(hs_al), .vs(vs_al), .hit(code_hit), .flags(code_fl),
    .pix_valid(pix_valid), .pix_y(pix_y), .pix_c(pix_c), .pix_c_is_cr(pix_c_is_cr),
    .eav_pulse(eav_pulse), .sav_pulse(sav_pulse), .field_flag(field_flag),
    .vblank_flag(vblank_flag), .hblank_flag(hblank_flag)
  );
endmodule

// File: rtl/yc422_capture_chk.sv
`timescale 1ns/1ps
module yc422_capture_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_sel,
  input logic       pix_valid,
  input logic       eav_pulse,
  input logic       sav_pulse,
  input logic       hblank_flag
);
  // R2: the two pulse kinds never coincide
  a_r2_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(eav_pulse && sav_pulse));

  // R2: an EAV pulse lasts one cycle
  a_r2_eav_single: assert property (@(posedge clk) disable iff (!rst_n)
    eav_pulse |=> !eav_pulse);

  // R3: an EAV always leaves the line in blanking
  a_r3_eav_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    eav_pulse |-> hblank_flag);

  // R6: no sample is delivered during horizontal blanking
  a_r6_valid_open: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> !hblank_flag);

  // R4: single-rate samples come at most every other cycle
  a_r4_sr_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_sel == 3'b000 || mode_sel == 3'b111) && pix_valid) |=> !pix_valid);

  // R9: unsupported mode codes stay quiet
  a_r9_bad_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_sel == 3'b000 || mode_sel == 3'b010 || mode_sel == 3'b111)
      |=> (!pix_valid && !eav_pulse && !sav_pulse));
endmodule

bind yc422_capture yc422_capture_chk i_chk (.*);

// File: tb/test_yc422_capture.sv
`timescale 1ns/1ps
module test_yc422_capture;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_sel = 3'b000;
  logic [1:0] luma_edge = 2'b00;
  logic [7:0] bus_d = 8'h10;
  logic       hsync_in = 1'b0, vsync_in = 1'b0;
  logic       pix_valid, pix_c_is_cr, eav_pulse, sav_pulse;
  logic       field_flag, vblank_flag, hblank_flag;
  logic [7:0] pix_y, pix_c;

  always #2 clk = ~clk;

  yc422_capture i_yc422_capture (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .luma_edge(luma_edge),
    .bus_d(bus_d), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .pix_valid(pix_valid), .pix_y(pix_y), .pix_c(pix_c), .pix_c_is_cr(pix_c_is_cr),
    .eav_pulse(eav_pulse), .sav_pulse(sav_pulse), .field_flag(field_flag),
    .vblank_flag(vblank_flag), .hblank_flag(hblank_flag)
  );

  int checks = 0, fails = 0;
  int n_valid = 0, n_eav = 0, n_sav = 0;
  string cur_req = "R1";

  // ---------------- behavioural reference model ----------------
  logic [7:0] f1, f2, s_prev, pp_f, pp_s;
  logic       h1, h2, v1, v2;
  logic [7:0] hist_q[$];
  bit m_act, m_ph, m_crn, m_h, m_v, m_f;
  logic [7:0] m_chold;
  bit e_valid, e_cr, e_eav, e_sav, e_f, e_vb, e_hb;
  logic [7:0] e_y, e_c;

  task automatic model_reset();
    f1 = 0; f2 = 0; s_prev = 0; pp_f = 0; pp_s = 0;
    h1 = 0; h2 = 0; v1 = 0; v2 = 0;
    hist_q = '{8'h00, 8'h00, 8'h00};
    m_act = 0; m_ph = 0; m_crn = 0; m_h = 1; m_v = 1; m_f = 0; m_chold = 0;
    e_valid = 0; e_cr = 0; e_eav = 0; e_sav = 0; e_f = 0; e_vb = 1; e_hb = 1;
    e_y = 0; e_c = 0;
  endtask

  task automatic model_step(input logic [7:0] f, input logic [7:0] s,
                            input bit h, input bit v);
    bit ok, sr, dd, ext, hext, vext, hit, ylead;
    logic [7:0] xy;
    sr    = (mode_sel == 3'd0) || (mode_sel == 3'd7);
    dd    = (mode_sel == 3'd2);
    ok    = sr || dd;
    ext   = (mode_sel == 3'd0) || dd;
    hext  = ext && h;
    vext  = ext && v;
    ylead = (luma_edge == 2'b00);
    hit   = 0;
    if (sr) hit = (hist_q[0] == 8'hFF) && (hist_q[1] == 8'h00) && (hist_q[2] == 8'h00);
    else if (dd) hit = (pp_f == 8'hFF) && (pp_s == 8'h00) && (f == 8'h00);
    xy = sr ? f : s;
    hist_q.push_back(f);
    hist_q.delete(0);
    pp_f = f; pp_s = s;
    e_valid = 0; e_eav = 0; e_sav = 0;
    if (!ok) m_act = 0;
    else if (hit) begin
      m_f = xy[6]; m_v = xy[5]; m_h = xy[4];
      e_eav = xy[4]; e_sav = !xy[4]; m_act = !xy[4]; m_ph = 0; m_crn = 0;
    end else if (m_act && f == 8'hFF) m_act = 0;
    else if (m_act && !hext) begin
      if (dd) begin
        e_y = ylead ? f : s; e_c = ylead ? s : f;
        e_cr = m_crn; m_crn = !m_crn; e_valid = 1;
      end else if (!m_ph) begin
        m_chold = f; m_ph = 1;
      end else begin
        e_y = f; e_c = m_chold; e_cr = m_crn; m_crn = !m_crn; m_ph = 0; e_valid = 1;
      end
    end
    e_hb = m_h | hext;
    e_vb = m_v | vext;
    e_f  = m_f;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) begin f1 = 0; f2 = 0; h1 = 0; h2 = 0; v1 = 0; v2 = 0; end
    else begin
      f2 = f1; f1 = bus_d; h2 = h1; h1 = hsync_in; v2 = v1; v1 = vsync_in;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) model_reset();
    else begin
      model_step(f2, s_prev, h2, v2);
      s_prev = bus_d;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(posedge clk) begin
    logic [22:0] act, exv;
    #1;
    act = {pix_valid, pix_valid ? pix_y : 8'h00, pix_valid ? pix_c : 8'h00,
           pix_valid ? pix_c_is_cr : 1'b0, eav_pulse, sav_pulse,
           field_flag, vblank_flag, hblank_flag};
    exv = {e_valid, e_valid ? e_y : 8'h00, e_valid ? e_c : 8'h00,
           e_valid ? e_cr : 1'b0, e_eav, e_sav, e_f, e_vb, e_hb};
    checks++;
    if (act !== exv) begin
      fails++;
      $display("FAIL %s outputs act=%h exp=%h at %0t", cur_req, act, exv, $time);
    end
    if (pix_valid) n_valid++;
    if (eav_pulse) n_eav++;
    if (sav_pulse) n_sav++;
  end

  // ---------------- stimulus helpers ----------------
  task automatic put(input logic [7:0] f, input logic [7:0] s,
                     input logic h = 1'b0, input logic v = 1'b0);
    bus_d = f; hsync_in = h; vsync_in = v;
    @(posedge clk); #1 bus_d = s;
    @(negedge clk); #1;
  endtask

  task automatic set_mode(input logic [2:0] m, input logic [1:0] e);
    @(posedge clk); #1 mode_sel = m; luma_edge = e;
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(8'h10, 8'h80);
  endtask

  task automatic sr_code(input logic [7:0] xy, input logic h = 1'b0);
    put(8'hFF, 8'hFF, h); put(8'h00, 8'h00, h); put(8'h00, 8'h00, h); put(xy, xy, h);
  endtask

  task automatic sr_line(input logic [7:0] sav, input logic [7:0] eav, input int npair,
                         input logic h = 1'b0, input int hs_at = -1);
    sr_code(sav, h);
    for (int i = 0; i < npair; i++) begin
      logic hh;
      hh = h | (i == hs_at);
      put(8'h01 + 8'(i), 8'h01 + 8'(i), hh);
      put(8'h80 + 8'(i), 8'h80 + 8'(i), hh);
      put(8'h40 + 8'(i), 8'h40 + 8'(i), hh);
      put(8'h02 + 8'(i), 8'h02 + 8'(i), hh);
    end
    sr_code(eav, h);
  endtask

  task automatic dd_line(input logic [7:0] sav, input logic [7:0] eav, input int npix,
                         input bit ylead, input int hs_at = -1);
    put(8'hFF, 8'h00); put(8'h00, sav);
    for (int i = 0; i < npix; i++) begin
      logic [7:0] y, c;
      y = 8'h20 + 8'(3 * i); c = 8'hC1 - 8'(5 * i);
      if (ylead) put(y, c, i == hs_at); else put(c, y, i == hs_at);
    end
    put(8'hFF, 8'h00); put(8'h00, eav);
  endtask

  task automatic check_count(input string req, input string what, input int act, input int exv);
    checks++;
    if (act != exv) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exv);
    end
  endtask

  task automatic clear_counts();
    n_valid = 0; n_eav = 0; n_sav = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // ---------------- scenario ----------------
  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state at the ports
    checks++;
    if ({pix_valid, eav_pulse, sav_pulse, field_flag, vblank_flag, hblank_flag} !== 6'b000011) begin
      fails++;
      $display("FAIL R1 reset act=%b exp=000011",
               {pix_valid, eav_pulse, sav_pulse, field_flag, vblank_flag, hblank_flag});
    end
    rst_n = 1'b1;
    @(negedge clk); #1;
    idle(4);

    // R4 R10 R2 R6: SD line, field 0 active
    cur_req = "R4"; clear_counts();
    sr_line(8'h80, 8'h90, 4);
    idle(3);
    check_count("R4", "SD samples", n_valid, 8);
    check_count("R2", "SD eav pulses", n_eav, 1);
    check_count("R2", "SD sav pulses", n_sav, 1);
    check_count("R6", "no samples after EAV", n_valid, 8);

    // R3: field 1 and vertical blanking bits
    cur_req = "R3";
    sr_line(8'hE0, 8'hF0, 2);
    idle(3);
    sr_line(8'h80, 8'h90, 1);
    idle(3);

    // R7: external sync in SD
    cur_req = "R7"; clear_counts();
    sr_line(8'h80, 8'h90, 4, 1'b0, 2);
    put(8'h10, 8'h10, 1'b0, 1'b1); put(8'h10, 8'h10, 1'b1, 1'b1);
    idle(3);
    check_count("R7", "SD samples with hsync pause", n_valid, 6);

    // R8: ED 54 mode ignores sync pins
    set_mode(3'b111, 2'b00);
    cur_req = "R8"; clear_counts();
    idle(2);
    sr_line(8'h80, 8'h90, 4, 1'b1);
    put(8'h10, 8'h10, 1'b1, 1'b1); put(8'h10, 8'h10, 1'b0, 1'b1);
    idle(3);
    check_count("R8", "ED54 samples with sync pins high", n_valid, 8);

    // R5: double-rate, luma on rising edge
    set_mode(3'b010, 2'b00);
    cur_req = "R5"; clear_counts();
    idle(2);
    dd_line(8'h80, 8'h90, 8, 1'b1);
    idle(3);
    check_count("R5", "DDR rising-luma samples", n_valid, 8);
    check_count("R2", "DDR eav pulses", n_eav, 1);

    // R5: double-rate, luma on falling edge
    set_mode(3'b010, 2'b11);
    clear_counts();
    idle(2);
    dd_line(8'h80, 8'h90, 6, 1'b0);
    idle(3);
    check_count("R5", "DDR falling-luma samples", n_valid, 6);

    // R7: external hsync in double-rate mode
    cur_req = "R7"; clear_counts();
    dd_line(8'hC0, 8'hD0, 6, 1'b0, 3);
    idle(3);
    check_count("R7", "DDR samples with hsync pause", n_valid, 5);

    // R9: unsupported mode code
    set_mode(3'b001, 2'b00);
    cur_req = "R9"; clear_counts();
    idle(2);
    sr_line(8'h80, 8'h90, 3);
    dd_line(8'h80, 8'h90, 3, 1'b1);
    idle(3);
    check_count("R9", "samples in bad mode", n_valid, 0);
    check_count("R9", "pulses in bad mode", n_eav + n_sav, 0);

    // back to SD: R10 bit order once more with extreme bit patterns
    set_mode(3'b000, 2'b00);
    cur_req = "R10"; clear_counts();
    idle(2);
    sr_code(8'h80);
    put(8'h01, 8'h01); put(8'h80, 8'h80); put(8'hFE, 8'hFE); put(8'h7F, 8'h7F);
    sr_code(8'h90);
    idle(3);
    check_count("R10", "SD edge-pattern samples", n_valid, 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule